// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a four-bank DDR SDRAM and owns the command bus from reset until the memory is usable. After a start strobe it holds the clock-enable pin low for a programmable settling time. It then raises clock-enable and walks the memory through a fixed series of commands: precharge of all banks, an extended-register load that enables the DLL, a base-register load that resets the DLL and sets the operating fields, a second precharge of all banks, two auto-refreshes and a last base-register load with the DLL reset bit cleared. Each step is spaced by a parameterized minimum gap.

The burst length, burst type and CAS latency codes are captured when the start strobe is accepted and placed in the base register's field positions. A separate counter measures the DLL lock time from the DLL reset load. The ready output only rises once both that time and the gap after the last load have elapsed. Ready stays high until reset, and the bus idles with NOPs from then on.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is low the outputs are cke_o=0, cs_n_o=1, ras_n_o=cas_n_o=we_n_o=1, ba_o=0, addr_o=0, ready_o=0. After reset and before any start, cke_o stays 0 and the bus shows NOP (cs_n_o=0, ras_n_o=cas_n_o=we_n_o=1).
- R2: When start_i is sampled high in the idle state, cke_o stays low with only NOP on the bus for exactly STARTUP_CYC cycles. It is high from the STARTUP_CYC-th clock edge after the start edge onward, and it never falls before reset.
- R3: Commands are encoded on {cs_n,ras_n,cas_n,we_n}: NOP=0111, PRECHARGE=0010, AUTO REFRESH=0001, LOAD MODE=0000. The non-NOP commands appear in this order: PRECHARGE, LOAD MODE, LOAD MODE, PRECHARGE, AUTO REFRESH, AUTO REFRESH, LOAD MODE. There are exactly seven of them, the first one cycle after cke_o rises, and every other cycle carries NOP.
- R4: Every PRECHARGE drives addr_o[10]=1, selecting all banks.
- R5: The first LOAD MODE targets the extended register: ba_o=01 and addr_o all zero, which leaves the DLL enabled.
- R6: The second and last LOAD MODE target the base register (ba_o=00). They carry addr_o[2:0]=burst length code, addr_o[3]=burst type, addr_o[6:4]=CAS latency code, and all other bits zero except addr_o[8]. addr_o[8] is 1 in the first of these loads (DLL reset) and 0 in the last.
- R7: The distance between consecutive commands is exactly T_RP cycles after a PRECHARGE, T_MRD after a LOAD MODE and T_RFC after an AUTO REFRESH.
- R8: ready_o rises exactly max(d+DLL_LOCK_CYC, f+T_MRD). Here d is the cycle of the DLL reset load and f is the cycle of the last LOAD MODE. It never rises earlier than DLL_LOCK_CYC cycles after the DLL reset load.
- R9: Once high, ready_o stays high until reset, cke_o stays high and the bus carries only NOP. Further start strobes change nothing.
- R10: A start strobe while the sequence is running has no effect on the command order or timing.
- R11: The mode field inputs are captured in the cycle start_i is accepted. Later changes to them do not alter either base-register load.
- R12: Reset asserted mid-sequence returns the outputs to the R1 values, and a new start then runs the complete sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, acted on only in idle |
| burst_len_i | input | 3 | Burst length code for the base register |
| burst_type_i | input | 1 | Burst type bit (0 sequential, 1 interleaved) |
| cas_lat_i | input | 3 | CAS latency code for the base register |
| cke_o | output | 1 | Memory clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BANK_W | Bank / register select |
| addr_o | output | ROW_W | Address / register value |
| ready_o | output | 1 | Initialization complete |

## Verification
The bench checks the exact cycle of the clock-enable rise and of the first precharge. A settling counter that is off by one would move either edge by a cycle. It checks that ready waits for the longer of the DLL lock window and the gap after the final load. A design that gated ready on the load gap alone would raise it about two hundred cycles early. Mode inputs are flipped and start is pulsed in the middle of a run, so a design that read the live inputs or restarted on a second strobe would produce wrong register contents or shifted command times. A reset in the middle of a run confirms that no step state survives into the next sequence.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  localparam int MR_BL_W     = 3;
  localparam int MR_CL_W     = 3;
  localparam int MR_BL_LSB   = 0;
  localparam int MR_BT_BIT   = 3;
  localparam int MR_CL_LSB   = 4;
  localparam int MR_DLL_BIT  = 8;
  localparam int AP_BIT      = 10;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CKE_UP,
    ST_PRE1,
    ST_EMR,
    ST_MRS_DLL,
    ST_PRE2,
    ST_REF1,
    ST_REF2,
    ST_MRS_RUN,
    ST_LOCK,
    ST_DONE
  } step_e;

  typedef enum logic [2:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_PRE,
    CMD_REF,
    CMD_LMR
  } cmd_e;

  // {cs_n, ras_n, cas_n, we_n}
  function automatic logic [3:0] cmd_pins(cmd_e c);
    logic [3:0] p;
    case (c)
      CMD_NOP: p = 4'b0111;
      CMD_PRE: p = 4'b0010;
      CMD_REF: p = 4'b0001;
      CMD_LMR: p = 4'b0000;
      default: p = 4'b1111;
    endcase
    return p;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_init_gap_timer.sv
module ddr_init_gap_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/ddr_init_lock_ctr.sv
module ddr_init_lock_ctr #(
  parameter int LOCK_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic done
);

  localparam int W = $clog2(LOCK_CYC + 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;
  logic         armed_q;

  always_comb begin
    cnt_en = arm || (armed_q && (cnt_q != '0));
    cnt_d  = arm ? W'(LOCK_CYC - 1) : (cnt_q - W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   armed_q <= 1'b0;
    else if (arm) armed_q <= 1'b1;
  end

  assign done = armed_q && (cnt_q == '0);

endmodule

// File: rtl/ddr_init_bus_reg.sv
module ddr_init_bus_reg import ddr_init_pkg::*; #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd,
  input  logic              cke_set,
  input  logic [BANK_W-1:0] ba_d,
  input  logic [ROW_W-1:0]  addr_d,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  addr_o
);

  logic [3:0] pins_d;

  assign pins_d = cmd_pins(cmd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cke_o <= 1'b0;
    else if (cke_set) cke_o <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_o  <= 1'b1;
      ras_n_o <= 1'b1;
      cas_n_o <= 1'b1;
      we_n_o  <= 1'b1;
      ba_o    <= '0;
      addr_o  <= '0;
    end else begin
      {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= pins_d;
      ba_o   <= ba_d;
      addr_o <= addr_d;
    end
  end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq import ddr_init_pkg::*; #(
  parameter int STARTUP_CYC  = 50000,
  parameter int T_RP         = 3,
  parameter int T_MRD        = 2,
  parameter int T_RFC        = 18,
  parameter int DLL_LOCK_CYC = 200,
  parameter int BANK_W       = 2,
  parameter int ROW_W        = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [MR_BL_W-1:0] burst_len_i,
  input  logic               burst_type_i,
  input  logic [MR_CL_W-1:0] cas_lat_i,
  output logic               cke_o,
  output logic               cs_n_o,
  output logic               ras_n_o,
  output logic               cas_n_o,
  output logic               we_n_o,
  output logic [BANK_W-1:0]  ba_o,
  output logic [ROW_W-1:0]   addr_o,
  output logic               ready_o
);

  localparam int MAX_GAP = imax(imax(STARTUP_CYC, T_RP), imax(T_MRD, T_RFC));
  localparam int TMR_W   = $clog2(MAX_GAP + 1);
  localparam logic [TMR_W-1:0] LD_START = TMR_W'(STARTUP_CYC - 1);
  localparam logic [TMR_W-1:0] LD_RP    = TMR_W'(T_RP - 1);
  localparam logic [TMR_W-1:0] LD_MRD   = TMR_W'(T_MRD - 1);
  localparam logic [TMR_W-1:0] LD_RFC   = TMR_W'(T_RFC - 1);
  localparam logic [BANK_W-1:0] BA_EXT  = BANK_W'(1);
  localparam logic [BANK_W-1:0] BA_BASE = BANK_W'(0);

  step_e              step_q, step_d;
  cmd_e               cmd_d;
  logic               tmr_ld;
  logic [TMR_W-1:0]   tmr_val;
  logic               tmr_zero;
  logic               lock_arm;
  logic               lock_done;
  logic               cke_set;
  logic               mode_ld;
  logic               ready_set;
  logic [BANK_W-1:0]  ba_d;
  logic [ROW_W-1:0]   addr_d;
  logic [MR_BL_W-1:0] bl_q;
  logic               bt_q;
  logic [MR_CL_W-1:0] cl_q;

  function automatic logic [ROW_W-1:0] base_word(logic dll_rst,
                                                 logic [MR_BL_W-1:0] bl,
                                                 logic bt,
                                                 logic [MR_CL_W-1:0] cl);
    logic [ROW_W-1:0] w;
    w = '0;
    w[MR_BL_LSB +: MR_BL_W] = bl;
    w[MR_BT_BIT]            = bt;
    w[MR_CL_LSB +: MR_CL_W] = cl;
    w[MR_DLL_BIT]           = dll_rst;
    return w;
  endfunction

  // next-state and command selection
  always_comb begin
    step_d    = step_q;
    cmd_d     = CMD_NOP;
    tmr_ld    = 1'b0;
    tmr_val   = '0;
    lock_arm  = 1'b0;
    cke_set   = 1'b0;
    mode_ld   = 1'b0;
    ready_set = 1'b0;
    ba_d      = '0;
    addr_d    = '0;
    if (step_q == ST_IDLE) begin
      if (start_i) begin
        step_d  = ST_CKE_UP;
        tmr_ld  = 1'b1;
        tmr_val = LD_START;
        mode_ld = 1'b1;
      end
    end else if (tmr_zero) begin
      case (step_q)
        ST_CKE_UP: begin
          cke_set = 1'b1;
          tmr_ld  = 1'b1;
          tmr_val = '0;
          step_d  = ST_PRE1;
        end
        ST_PRE1, ST_PRE2: begin
          cmd_d          = CMD_PRE;
          addr_d[AP_BIT] = 1'b1;
          tmr_ld         = 1'b1;
          tmr_val        = LD_RP;
          step_d         = (step_q == ST_PRE1) ? ST_EMR : ST_REF1;
        end
        ST_EMR: begin
          cmd_d   = CMD_LMR;
          ba_d    = BA_EXT;
          tmr_ld  = 1'b1;
          tmr_val = LD_MRD;
          step_d  = ST_MRS_DLL;
        end
        ST_MRS_DLL: begin
          cmd_d    = CMD_LMR;
          ba_d     = BA_BASE;
          addr_d   = base_word(1'b1, bl_q, bt_q, cl_q);
          tmr_ld   = 1'b1;
          tmr_val  = LD_MRD;
          lock_arm = 1'b1;
          step_d   = ST_PRE2;
        end
        ST_REF1, ST_REF2: begin
          cmd_d   = CMD_REF;
          tmr_ld  = 1'b1;
          tmr_val = LD_RFC;
          step_d  = (step_q == ST_REF1) ? ST_REF2 : ST_MRS_RUN;
        end
        ST_MRS_RUN: begin
          cmd_d   = CMD_LMR;
          ba_d    = BA_BASE;
          addr_d  = base_word(1'b0, bl_q, bt_q, cl_q);
          tmr_ld  = 1'b1;
          tmr_val = LD_MRD;
          step_d  = ST_LOCK;
        end
        ST_LOCK: begin
          if (lock_done) begin
            ready_set = 1'b1;
            step_d    = ST_DONE;
          end
        end
        default: step_d = step_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= ST_IDLE;
    else        step_q <= step_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bl_q <= '0;
      bt_q <= 1'b0;
      cl_q <= '0;
    end else if (mode_ld) begin
      bl_q <= burst_len_i;
      bt_q <= burst_type_i;
      cl_q <= cas_lat_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ready_o <= 1'b0;
    else if (ready_set) ready_o <= 1'b1;
  end

  ddr_init_gap_timer #(.W(TMR_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_ld),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  ddr_init_lock_ctr #(.LOCK_CYC(DLL_LOCK_CYC)) u_lock (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (lock_arm),
    .done  (lock_done)
  );

  ddr_init_bus_reg #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_bus (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd_d),
    .cke_set (cke_set),
    .ba_d    (ba_d),
    .addr_d  (addr_d),
    .cke_o   (cke_o),
    .cs_n_o  (cs_n_o),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .we_n_o  (we_n_o),
    .ba_o    (ba_o),
    .addr_o  (addr_o)
  );

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk import ddr_init_pkg::*; #(
  parameter int T_RP         = 3,
  parameter int T_MRD        = 2,
  parameter int T_RFC        = 18,
  parameter int DLL_LOCK_CYC = 200,
  parameter int BANK_W       = 2,
  parameter int ROW_W        = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke_o,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [BANK_W-1:0] ba_o,
  input logic [ROW_W-1:0]  addr_o,
  input logic              ready_o
);

  localparam int GMAX = imax(imax(T_RP, T_MRD), T_RFC);
  localparam int GW   = $clog2(GMAX + 2);
  localparam int LW   = $clog2(DLL_LOCK_CYC + 2);

  logic       is_cmd, is_pre, is_ref, is_lmr, is_dll_rst;
  logic [1:0] last_q;
  logic [GW-1:0] since_q;
  logic [LW-1:0] lk_q;
  logic       seen_q;
  logic       gap_ok;

  assign is_cmd     = !cs_n_o && !(ras_n_o && cas_n_o && we_n_o);
  assign is_pre     = is_cmd && !ras_n_o && cas_n_o && !we_n_o;
  assign is_ref     = is_cmd && !ras_n_o && !cas_n_o && we_n_o;
  assign is_lmr     = is_cmd && !ras_n_o && !cas_n_o && !we_n_o;
  assign is_dll_rst = is_lmr && (ba_o == '0) && addr_o[MR_DLL_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= 2'd0;
      since_q <= '0;
    end else if (is_cmd) begin
      last_q  <= is_pre ? 2'd1 : (is_ref ? 2'd2 : (is_lmr ? 2'd3 : 2'd0));
      since_q <= GW'(1);
    end else if (since_q != {GW{1'b1}}) begin
      since_q <= since_q + GW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      lk_q   <= '0;
    end else if (is_dll_rst) begin
      seen_q <= 1'b1;
      lk_q   <= LW'(1);
    end else if (seen_q && (lk_q < LW'(DLL_LOCK_CYC))) begin
      lk_q   <= lk_q + LW'(1);
    end
  end

  always_comb begin
    case (last_q)
      2'd1:    gap_ok = (since_q >= GW'(T_RP));
      2'd2:    gap_ok = (since_q >= GW'(T_RFC));
      2'd3:    gap_ok = (since_q >= GW'(T_MRD));
      default: gap_ok = 1'b1;
    endcase
  end

  p_cke_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_o |-> (ras_n_o && cas_n_o && we_n_o));

  p_cke_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cke_o |=> cke_o);

  p_pre_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> addr_o[AP_BIT]);

  p_min_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd |-> gap_ok);

  p_lock_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> (seen_q && (lk_q >= LW'(DLL_LOCK_CYC))));

  p_ready_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o);

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (cke_o && !is_cmd));

endmodule

bind ddr_init_seq ddr_init_seq_chk #(
  .T_RP         (T_RP),
  .T_MRD        (T_MRD),
  .T_RFC        (T_RFC),
  .DLL_LOCK_CYC (DLL_LOCK_CYC),
  .BANK_W       (BANK_W),
  .ROW_W        (ROW_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cke_o   (cke_o),
  .cs_n_o  (cs_n_o),
  .ras_n_o (ras_n_o),
  .cas_n_o (cas_n_o),
  .we_n_o  (we_n_o),
  .ba_o    (ba_o),
  .addr_o  (addr_o),
  .ready_o (ready_o)
);

// File: tb/ddr_init_seq_test.sv
`timescale 1ns/1ps
module ddr_init_seq_test;

  localparam int S_CYC = 40;
  localparam int TRP   = 3;
  localparam int TMRD  = 2;
  localparam int TRFC  = 7;
  localparam int TLOCK = 200;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [2:0]  burst_len_i;
  logic        burst_type_i;
  logic [2:0]  cas_lat_i;
  logic        cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o;
  logic [1:0]  ba_o;
  logic [12:0] addr_o;
  logic        ready_o;

  int checks = 0;
  int errors = 0;

  ddr_init_seq #(
    .STARTUP_CYC(S_CYC), .T_RP(TRP), .T_MRD(TMRD), .T_RFC(TRFC),
    .DLL_LOCK_CYC(TLOCK), .BANK_W(2), .ROW_W(13)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .burst_len_i(burst_len_i), .burst_type_i(burst_type_i), .cas_lat_i(cas_lat_i),
    .cke_o(cke_o), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
    .we_n_o(we_n_o), .ba_o(ba_o), .addr_o(addr_o), .ready_o(ready_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_base(logic [2:0] bl, logic bt, logic [2:0] cl, logic dll);
    logic [12:0] w;
    w = '0;
    w[2:0] = bl;
    w[3]   = bt;
    w[6:4] = cl;
    w[8]   = dll;
    return int'(w);
  endfunction

  function automatic logic [2:0] pick_bl(int r);
    case (r % 3)
      0:       return 3'b001;
      1:       return 3'b010;
      default: return 3'b011;
    endcase
  endfunction

  function automatic logic [2:0] pick_cl(int r);
    case (r % 3)
      0:       return 3'b010;
      1:       return 3'b110;
      default: return 3'b011;
    endcase
  endfunction

  function automatic int imax2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check_reset_state(input string req);
    chk(req, "cke during reset", int'(cke_o), 0);
    chk(req, "pins during reset", int'({cs_n_o, ras_n_o, cas_n_o, we_n_o}), 4'hF);
    chk(req, "ba/addr during reset", int'({ba_o, addr_o}), 0);
    chk(req, "ready during reset", int'(ready_o), 0);
  endtask

  task automatic run_seq(input logic [2:0] bl, input logic bt, input logic [2:0] cl,
                         input bit poke_start, input bit poke_mode, input string tag);
    int k, cke_k, rdy_k, ncmd, bad_order, cke_fall;
    int ck[8];
    logic [3:0]  cp[8];
    logic [1:0]  cba[8];
    logic [12:0] cad[8];
    bit early;
    logic [3:0] exp_p[7];
    int exp_gap[6];
    string rq;
    exp_p = '{4'b0010, 4'b0000, 4'b0000, 4'b0010, 4'b0001, 4'b0001, 4'b0000};
    exp_gap = '{TRP, TMRD, TMRD, TRP, TRFC, TRFC};
    for (int i = 0; i < 8; i++) begin ck[i] = 0; cp[i] = '1; cba[i] = '0; cad[i] = '0; end
    burst_len_i = bl; burst_type_i = bt; cas_lat_i = cl;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    k = 1; cke_k = 0; rdy_k = 0; ncmd = 0; early = 0; cke_fall = 0;
    while (rdy_k == 0 && k < 1000) begin
      if (cke_o && cke_k == 0) cke_k = k;
      if (!cke_o && cke_k != 0) cke_fall = 1;
      if (!cs_n_o && !(ras_n_o && cas_n_o && we_n_o)) begin
        if (cke_k == 0) early = 1;
        if (ncmd < 8) begin
          ck[ncmd] = k; cp[ncmd] = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
          cba[ncmd] = ba_o; cad[ncmd] = addr_o;
        end
        ncmd++;
      end
      if (ready_o) rdy_k = k;
      if (poke_mode && k == 3) begin
        burst_len_i = ~bl; burst_type_i = ~bt; cas_lat_i = ~cl;
      end
      if (poke_start && (k == S_CYC + 4 || k == S_CYC + 30 || k == 10)) start_i = 1'b1;
      else start_i = 1'b0;
      @(negedge clk);
      k++;
    end
    start_i = 1'b0;
    rq = poke_start ? "R10" : "R2";
    chk(rq, {tag, " cke rise sample"}, cke_k, S_CYC + 1);
    chk("R2", {tag, " command while cke low"}, int'(early), 0);
    chk("R2", {tag, " cke fell"}, cke_fall, 0);
    chk("R3", {tag, " command count"}, ncmd, 7);
    bad_order = 0;
    for (int i = 0; i < 7; i++) if (cp[i] != exp_p[i]) bad_order++;
    chk("R3", {tag, " commands out of order"}, bad_order, 0);
    chk("R3", {tag, " first precharge sample"}, ck[0], S_CYC + 2);
    chk("R4", {tag, " precharge A10"}, int'({cad[0][10], cad[3][10]}), 3);
    chk("R5", {tag, " ext load bank"}, int'(cba[1]), 1);
    chk("R5", {tag, " ext load addr"}, int'(cad[1]), 0);
    rq = poke_mode ? "R11" : "R6";
    chk(rq, {tag, " DLL reset load bank"}, int'(cba[2]), 0);
    chk(rq, {tag, " DLL reset load addr"}, int'(cad[2]), exp_base(bl, bt, cl, 1'b1));
    chk(rq, {tag, " final load bank"}, int'(cba[6]), 0);
    chk(rq, {tag, " final load addr"}, int'(cad[6]), exp_base(bl, bt, cl, 1'b0));
    for (int i = 0; i < 6; i++)
      chk(poke_start ? "R10" : "R7", {tag, " gap"}, ck[i+1] - ck[i], exp_gap[i]);
    chk("R8", {tag, " ready sample"}, rdy_k, imax2(ck[2] + TLOCK, ck[6] + TMRD));
  endtask

  task automatic check_hold(input string tag);
    int bad;
    bad = 0;
    for (int i = 0; i < 24; i++) begin
      start_i = (i % 5 == 1);
      burst_len_i = 3'(i);
      @(negedge clk);
      if (!ready_o || !cke_o || {cs_n_o, ras_n_o, cas_n_o, we_n_o} != 4'b0111) bad++;
    end
    start_i = 1'b0;
    chk("R9", {tag, " bus not idle with ready held"}, bad, 0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0;
    burst_len_i = '0; burst_type_i = 1'b0; cas_lat_i = '0;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check_reset_state("R1");
    rst_n = 1'b1;
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (cke_o || ready_o || {cs_n_o, ras_n_o, cas_n_o, we_n_o} != 4'b0111) bad++;
      end
      chk("R1", "idle before start not NOP/cke low", bad, 0);
    end

    run_seq(3'b010, 1'b0, 3'b010, 1'b0, 1'b0, "directed");
    check_hold("directed");

    for (int it = 0; it < 4; it++) begin
      logic [2:0] bl, cl;
      logic bt;
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      bl = pick_bl(int'($urandom % 3));
      cl = pick_cl(int'($urandom % 3));
      bt = 1'($urandom % 2);
      run_seq(bl, bt, cl, it[0], it[1], "random");
      check_hold("random");
    end

    // R12: reset in the middle of a run
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    burst_len_i = 3'b011; burst_type_i = 1'b1; cas_lat_i = 3'b011;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    repeat (S_CYC + 8) @(negedge clk);
    chk("R12", "cke high before mid reset", int'(cke_o), 1);
    #1 rst_n = 1'b0;
    #0.5;
    check_reset_state("R12");
    @(negedge clk) rst_n = 1'b1;
    run_seq(3'b001, 1'b1, 3'b110, 1'b0, 1'b0, "after mid reset");
    check_hold("after mid reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements): actual hung, expected completed run");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule